// File: doc/BRIEF.md
# Wake Event PME Controller

This block produces the power-management event request of a network controller. Three wake sources feed it as single-cycle pulses: a wake-frame match, a magic-packet match and a link-status change. Each source has its own enable. A source that fires while it is enabled sets a status bit. The status bit pulls the open-drain, active-low PME line low when the global PME enable is also set. A separate forced-assert control pulls the line low whatever the enable or the status holds. The output is an output-enable: 1 means the pin is pulled low, and the block never drives the pin high.

Software clears the status bit by writing one to it. Software also owns a 2-bit power-state field. In non-sticky mode, a return of that field to full power releases the status bit without software. In sticky mode the bit is held until software clears it. When a reset-clear option is set, a rising edge of the bus reset line forces the power-state field back to full power. The block also publishes a capability pointer and a capability flag. Both read zero when power management is disabled.

Top module: `pme_wake_ctrl`

## Requirements
- R1: After rst_n is released, pme_sts is 0, pstate is 00 and pme_oe is 0.
- R2: Source i (wake_ev bit 0 = wake frame, bit 1 = magic packet, bit 2 = link change) sets pme_sts at the next clock edge only if its enable wake_en[i] is 1. A pulse with its enable at 0 leaves pme_sts unchanged.
- R3: In legacy wake mode (legacy_wake_mode=1), legacy_magic_dflt enables the magic-packet source (bit 1) even when wake_en[1] is 0. This holds only while pm_enable is 1; with pm_enable at 0, legacy_magic_dflt has no effect.
- R4: When force_pme is 0, pme_oe equals pme_sts AND pme_enable.
- R5: When force_pme is 1, pme_oe is 1 in the same cycle, whatever pme_enable and pme_sts hold.
- R6: A sts_clr pulse clears pme_sts at the next edge. If an enabled wake event arrives in the same cycle, pme_sts stays 1.
- R7: With sticky_mode=1, a change of pstate to 00 leaves pme_sts unchanged.
- R8: With sticky_mode=0, a change of pstate from a nonzero value to 00 clears pme_sts at the same edge. An enabled wake event in that same cycle keeps pme_sts at 1.
- R9: With bus_rst_clr_en=1, a rising edge of bus_rst sets pstate to 00 and takes priority over a write in that cycle. With bus_rst_clr_en=0 the edge does not change pstate, and holding bus_rst high does not change pstate again after the edge.
- R10: A ps_wr pulse loads ps_wdata into pstate at the next edge (encoding 00=D0, 01=D1, 10=D2, 11=D3).
- R11: cap_ptr equals CAP_PTR_VAL (default 8'h50) and pm_cap_flag is 1 when pm_enable is 1. Both are 0 when pm_enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_ev | input | NSRC | Wake pulses: bit0 frame, bit1 magic, bit2 link |
| wake_en | input | NSRC | Per-source enables |
| legacy_wake_mode | input | 1 | Legacy wake mode select |
| legacy_magic_dflt | input | 1 | Magic-packet default enable for legacy mode |
| pm_enable | input | 1 | Power-management capability enable |
| pme_enable | input | 1 | Global PME output enable |
| sticky_mode | input | 1 | 1: status is held until software clears it |
| force_pme | input | 1 | Forces the PME line active |
| sts_clr | input | 1 | Write-one-to-clear strobe for the status bit |
| ps_wr | input | 1 | Power-state write strobe |
| ps_wdata | input | 2 | Power-state write value |
| bus_rst | input | 1 | Bus reset level (active high) |
| bus_rst_clr_en | input | 1 | Lets a bus reset edge clear the power state |
| pme_oe | output | 1 | 1 pulls the open-drain PME line low |
| pme_sts | output | 1 | PME status bit |
| pstate | output | 2 | Current power-state field |
| cap_ptr | output | CPW | Capability pointer |
| pm_cap_flag | output | 1 | Power-management capability flag |

## Verification
The bench targets the collisions. It sends a clear together with an event, and a return to D0 together with an event. A design that ranks clear or release above the event loses the wake. It drives D0 returns in both sticky and non-sticky mode, so a design that releases in the wrong mode either drops a latched wake or never releases the line. Bus reset is tested with the clear option off, on, and held high while a write follows. A design that works on level instead of edge would block the write. The legacy magic default is tried with power management disabled, where a design that ignores the gate would raise a wake it should not.

// File: rtl/pme_pkg.sv
package pme_pkg;
    localparam int PS_W = 2;
    typedef logic [PS_W-1:0] pstate_t;
    localparam pstate_t PS_FULL = '0;

    typedef struct packed {
        logic sts;
    } sts_state_t;

    typedef struct packed {
        pstate_t ps;
        logic    brst;
    } ps_state_t;
endpackage

// File: rtl/pme_src_gate.sv
module pme_src_gate #(
    parameter int NSRC      = 3,
    parameter int MAGIC_IDX = 1
) (
    input  logic [NSRC-1:0] wake_ev,
    input  logic [NSRC-1:0] wake_en,
    input  logic            legacy_wake_mode,
    input  logic            legacy_magic_dflt,
    input  logic            pm_enable,
    output logic            hit
);
    logic [NSRC-1:0] en_eff;
    logic            dflt_on;

    assign dflt_on = legacy_wake_mode & legacy_magic_dflt & pm_enable;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i == MAGIC_IDX) begin : g_magic
            assign en_eff[i] = wake_en[i] | dflt_on;
        end else begin : g_plain
            assign en_eff[i] = wake_en[i];
        end
    end

    assign hit = |(wake_ev & en_eff);
endmodule

// File: rtl/pme_pstate_reg.sv
module pme_pstate_reg
    import pme_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ps_wr,
    input  pstate_t ps_wdata,
    input  logic    bus_rst,
    input  logic    bus_rst_clr_en,
    output pstate_t ps_q_o,
    output logic    to_full
);
    ps_state_t st_d, st_q;
    logic      rst_rise;

    always_comb begin
        st_d      = st_q;
        rst_rise  = bus_rst & ~st_q.brst;
        st_d.brst = bus_rst;
        if (rst_rise && bus_rst_clr_en) begin
            st_d.ps = PS_FULL;
        end else if (ps_wr) begin
            st_d.ps = ps_wdata;
        end
        to_full = (st_q.ps != PS_FULL) && (st_d.ps == PS_FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ps: PS_FULL, brst: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ps_q_o = st_q.ps;

    assert_busclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst && !st_q.brst && bus_rst_clr_en) |=> (ps_q_o == PS_FULL));
    assert_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_wr && !(bus_rst && !st_q.brst && bus_rst_clr_en)) |=> (ps_q_o == $past(ps_wdata)));
endmodule

// File: rtl/pme_status_reg.sv
module pme_status_reg
    import pme_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic sts_clr,
    input  logic sticky_mode,
    input  logic to_full,
    output logic sts_o
);
    sts_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hit) begin
            st_d.sts = 1'b1;
        end else if (sts_clr || (to_full && !sticky_mode)) begin
            st_d.sts = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sts: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_o = st_q.sts;

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> sts_o);
    assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr && !hit) |=> !sts_o);
    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_mode && sts_o && !sts_clr) |=> sts_o);
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sticky_mode && to_full && !hit) |=> !sts_o);
endmodule

// File: rtl/pme_wake_ctrl.sv
module pme_wake_ctrl
    import pme_pkg::*;
#(
    parameter int           NSRC        = 3,
    parameter int           MAGIC_IDX   = 1,
    parameter int           CPW         = 8,
    parameter logic [CPW-1:0] CAP_PTR_VAL = 8'h50
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] wake_ev,
    input  logic [NSRC-1:0] wake_en,
    input  logic            legacy_wake_mode,
    input  logic            legacy_magic_dflt,
    input  logic            pm_enable,
    input  logic            pme_enable,
    input  logic            sticky_mode,
    input  logic            force_pme,
    input  logic            sts_clr,
    input  logic            ps_wr,
    input  logic [PS_W-1:0] ps_wdata,
    input  logic            bus_rst,
    input  logic            bus_rst_clr_en,
    output logic            pme_oe,
    output logic            pme_sts,
    output logic [PS_W-1:0] pstate,
    output logic [CPW-1:0]  cap_ptr,
    output logic            pm_cap_flag
);
    logic hit;
    logic to_full;

    pme_src_gate #(.NSRC(NSRC), .MAGIC_IDX(MAGIC_IDX)) u_gate (
        .wake_ev(wake_ev), .wake_en(wake_en),
        .legacy_wake_mode(legacy_wake_mode), .legacy_magic_dflt(legacy_magic_dflt),
        .pm_enable(pm_enable), .hit(hit)
    );

    pme_pstate_reg u_ps (
        .clk(clk), .rst_n(rst_n), .ps_wr(ps_wr), .ps_wdata(ps_wdata),
        .bus_rst(bus_rst), .bus_rst_clr_en(bus_rst_clr_en),
        .ps_q_o(pstate), .to_full(to_full)
    );

    pme_status_reg u_sts (
        .clk(clk), .rst_n(rst_n), .hit(hit), .sts_clr(sts_clr),
        .sticky_mode(sticky_mode), .to_full(to_full), .sts_o(pme_sts)
    );

    assign pme_oe      = (pme_sts & pme_enable) | force_pme;
    assign cap_ptr     = pm_enable ? CAP_PTR_VAL : '0;
    assign pm_cap_flag = pm_enable;

    assert_gate_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_pme && !pme_enable) |-> !pme_oe);
    assert_cap_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pm_enable |-> (cap_ptr == '0 && !pm_cap_flag));
endmodule

// File: tb/pme_wake_ctrl_bench.sv
module pme_wake_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    logic clk = 0, rst_n = 0;
    logic [2:0] wake_ev = 0, wake_en = 0;
    logic legacy_wake_mode = 0, legacy_magic_dflt = 0, pm_enable = 0, pme_enable = 0;
    logic sticky_mode = 0, force_pme = 0, sts_clr = 0, ps_wr = 0;
    logic [1:0] ps_wdata = 0;
    logic bus_rst = 0, bus_rst_clr_en = 0;
    logic pme_oe, pme_sts, pm_cap_flag;
    logic [1:0] pstate;
    logic [7:0] cap_ptr;
    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pme_wake_ctrl u_pme_wake_ctrl (.*);

    // {ev,en,pme_en,clr,wr,wd,sticky, exp_sts,exp_oe,exp_ps}
    localparam logic [15:0] VEC [NV] = '{
        {3'b001,3'b000,1'b0,1'b0,1'b0,2'b00,1'b0, 1'b0,1'b0,2'b00}, // R2 disabled
        {3'b001,3'b001,1'b0,1'b0,1'b0,2'b00,1'b0, 1'b1,1'b0,2'b00}, // R2 R4
        {3'b000,3'b000,1'b1,1'b0,1'b0,2'b00,1'b0, 1'b1,1'b1,2'b00}, // R4
        {3'b000,3'b000,1'b1,1'b1,1'b0,2'b00,1'b0, 1'b0,1'b0,2'b00}, // R6
        {3'b100,3'b100,1'b1,1'b1,1'b0,2'b00,1'b0, 1'b1,1'b1,2'b00}, // R6 event wins
        {3'b000,3'b000,1'b1,1'b0,1'b1,2'b11,1'b0, 1'b1,1'b1,2'b11}, // R10
        {3'b000,3'b000,1'b1,1'b0,1'b1,2'b00,1'b0, 1'b0,1'b0,2'b00}, // R8
        {3'b010,3'b010,1'b1,1'b0,1'b0,2'b00,1'b1, 1'b1,1'b1,2'b00}, // R2
        {3'b000,3'b000,1'b1,1'b0,1'b1,2'b10,1'b1, 1'b1,1'b1,2'b10}, // R10
        {3'b000,3'b000,1'b1,1'b0,1'b1,2'b00,1'b1, 1'b1,1'b1,2'b00}, // R7
        {3'b000,3'b000,1'b1,1'b1,1'b0,2'b00,1'b1, 1'b0,1'b0,2'b00}, // R6
        {3'b000,3'b000,1'b1,1'b0,1'b1,2'b01,1'b0, 1'b0,1'b0,2'b01}, // R10
        {3'b001,3'b001,1'b1,1'b0,1'b1,2'b00,1'b0, 1'b1,1'b1,2'b00}  // R8 event wins
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 sts", {7'b0, pme_sts}, 8'd0);
        chk("R1 ps", {6'b0, pstate}, 8'd0);
        chk("R1 oe", {7'b0, pme_oe}, 8'd0);
        chk("R11 cap off", cap_ptr, 8'h00);
        chk("R11 flag off", {7'b0, pm_cap_flag}, 8'd0);

        for (int i = 0; i < NV; i++) begin
            {wake_ev, wake_en, pme_enable, sts_clr, ps_wr, ps_wdata, sticky_mode} = VEC[i][15:4];
            step();
            chk($sformatf("R2/R4/R6-R8/R10 vec%0d sts", i), {7'b0, pme_sts}, {7'b0, VEC[i][3]});
            chk($sformatf("R4 vec%0d oe", i), {7'b0, pme_oe}, {7'b0, VEC[i][2]});
            chk($sformatf("R10 vec%0d ps", i), {6'b0, pstate}, {6'b0, VEC[i][1:0]});
        end
        wake_ev = 0; wake_en = 0; sts_clr = 0; ps_wr = 0;

        // R5: force with status 0 and enable 0
        sts_clr = 1; step(); sts_clr = 0; pme_enable = 0;
        force_pme = 1; #1;
        chk("R5 force", {7'b0, pme_oe}, 8'd1);
        force_pme = 0; #1;
        chk("R5 release", {7'b0, pme_oe}, 8'd0);

        // R3: legacy magic default gated by pm_enable
        legacy_wake_mode = 1; legacy_magic_dflt = 1; pm_enable = 0;
        wake_ev = 3'b010; step(); wake_ev = 0;
        chk("R3 gated off", {7'b0, pme_sts}, 8'd0);
        pm_enable = 1; #1;
        chk("R11 cap on", cap_ptr, 8'h50);
        chk("R11 flag on", {7'b0, pm_cap_flag}, 8'd1);
        wake_ev = 3'b010; step(); wake_ev = 0;
        chk("R3 default on", {7'b0, pme_sts}, 8'd1);
        legacy_wake_mode = 0; legacy_magic_dflt = 0;

        // R9: bus reset edge
        ps_wr = 1; ps_wdata = 2'b11; step(); ps_wr = 0;
        bus_rst = 1; step();
        chk("R9 clr disabled", {6'b0, pstate}, 8'd3);
        bus_rst = 0; step();
        bus_rst_clr_en = 1; bus_rst = 1; ps_wr = 1; ps_wdata = 2'b10; step(); ps_wr = 0;
        chk("R9 edge clears over write", {6'b0, pstate}, 8'd0);
        ps_wr = 1; ps_wdata = 2'b10; step(); ps_wr = 0;
        chk("R9 level no effect", {6'b0, pstate}, 8'd2);
        step();
        chk("R9 held", {6'b0, pstate}, 8'd2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule